// File: doc/BRIEF.md
# Strided MMIO Task-File Bridge

This bridge lets a memory-mapped bus reach the registers of a parallel ATA task file through a 4 KB window. Inside the window the registers sit 16 bytes apart, so address bits [11:4] select a register slot and all other address bits are ignored. The bridge accepts one access at a time and sorts it by size. Byte accesses reach the command-block registers and the control register. Halfword and word accesses reach only the data port, which sits at slot 0.

Every access that maps to a register becomes a one-cycle read or write strobe on the task-file port. The strobe carries a register number and, for the data port, an access width. Data that crosses the data port is byte-reversed in both directions, so a big-endian bus sees little-endian drive data in its natural order. An access to a slot that maps to nothing produces no strobe. A read of such a slot returns all ones at the access width. Every access, mapped or not, completes after the same fixed number of cycles with a single-cycle ready pulse.

Top module: `mmio_tf_bridge`

## Requirements
- R1: The register slot is bus_addr[11:4]. Address bits above bit 11 and below bit 4 have no effect on routing or data.
- R2: A byte access (bus_size=0) to slot 1 to 7 strobes task-file register number equal to the slot. A byte write sends {24'b0, bus_wdata[7:0]}. A byte read returns {24'b0, tf_rdata[7:0]}.
- R3: A byte write to slot 8 or slot 22 strobes register number 8, the device-control register. A byte read from either slot strobes a read of register number 8, which is alternate status.
- R4: A byte access to any other slot, slot 0 included, raises no strobe. Such a read returns 32'h000000FF.
- R5: A halfword (bus_size=1) or word (bus_size=2) access to slot 0 strobes register 0 with tf_size equal to bus_size. At any other slot it raises no strobe, and a read returns 32'h0000FFFF for a halfword or 32'hFFFFFFFF for a word. Size code 3 never strobes and reads 32'hFFFFFFFF.
- R6: On a halfword access to the data port, the two bytes are swapped in both directions. A write of 16'hAABB drives tf_wdata = 32'h0000BBAA. A read with tf_rdata[15:0] = 16'hCCDD returns 32'h0000DDCC.
- R7: On a word access to the data port, all four bytes are reversed in both directions. 32'h11223344 becomes 32'h44332211.
- R8: A request sampled while the bridge is idle is accepted. Its strobe, when it has one, is high for exactly the next cycle. bus_ready is high for exactly the cycle after that, and bus_rdata is valid in that cycle.
- R9: A request presented while an earlier access is still in flight is not accepted and raises no strobe.
- R10: While rst_n is low, tf_rd, tf_wr and bus_ready are low and any access in flight is dropped. The bridge accepts requests again from the third rising edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| tf_reg | output | 4 | Task-file register number (0 data, 1-7 command block, 8 control/alternate status) |
| tf_size | output | 2 | Access width, meaningful for register 0 |
| tf_rd | output | 1 | One-cycle read strobe |
| tf_wr | output | 1 | One-cycle write strobe |
| tf_wdata | output | 32 | Write data toward the task file |
| tf_rdata | input | 32 | Read data from the task file, sampled in the strobe cycle |

## Verification
Counting from the rising edge that accepts a request, the strobe with its register number, width and write data is due in the first cycle after that edge. The ready pulse and the read data are due in the second cycle, and both ready and the strobes are low again in the third. The bench drives each request just after a falling edge. It then samples on the next three falling edges and compares strobe, register, width, data and ready against a behavioural model at every one of those points. A second request held during the strobe cycle, and a reset pulled in mid-access, are checked by watching the strobes over the following cycles.

// File: rtl/mmio_tf_pkg.sv
package mmio_tf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;

endpackage

// File: rtl/mmio_tf_decode.sv
module mmio_tf_decode
  import mmio_tf_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int REG_W      = 4,
  parameter int NUM_CMD    = 7,
  parameter int CTRL_SLOT0 = 8,
  parameter int CTRL_SLOT1 = 22,
  parameter int CTRL_REG   = 8
) (
  input  logic [IDX_W-1:0] slot,
  input  logic [1:0]       size,
  output logic             hit,
  output logic [REG_W-1:0] reg_sel
);

  localparam logic [IDX_W-1:0] SLOT_C0 = IDX_W'(CTRL_SLOT0);
  localparam logic [IDX_W-1:0] SLOT_C1 = IDX_W'(CTRL_SLOT1);
  localparam logic [IDX_W-1:0] SLOT_LO = IDX_W'(1);
  localparam logic [IDX_W-1:0] SLOT_HI = IDX_W'(NUM_CMD);

  logic cmd_hit;
  logic ctl_hit;
  logic dat_hit;

  always_comb begin
    cmd_hit = (slot >= SLOT_LO) && (slot <= SLOT_HI);
    ctl_hit = (slot == SLOT_C0) || (slot == SLOT_C1);
    dat_hit = (slot == '0);
    hit     = 1'b0;
    reg_sel = '0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        hit = cmd_hit || ctl_hit;
        if (ctl_hit) reg_sel = REG_W'(CTRL_REG);
        else if (cmd_hit) reg_sel = slot[REG_W-1:0];
      end
      SZ_HALF, SZ_WORD: begin
        hit = dat_hit;
      end
      default: hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/mmio_tf_lane_rev.sv
module mmio_tf_lane_rev #(
  parameter int BYTES = 4
) (
  input  logic [BYTES*8-1:0] din,
  output logic [BYTES*8-1:0] dout
);

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign dout[g*8 +: 8] = din[(BYTES-1-g)*8 +: 8];
  end

endmodule

// File: rtl/mmio_tf_bridge.sv
module mmio_tf_bridge
  import mmio_tf_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int REG_W       = 4,
  parameter int NUM_CMD     = 7,
  parameter int CTRL_SLOT0  = 8,
  parameter int CTRL_SLOT1  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [REG_W-1:0]  tf_reg,
  output logic [1:0]        tf_size,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [DATA_W-1:0] tf_wdata,
  input  logic [DATA_W-1:0] tf_rdata
);

  localparam int IDX_W    = WIN_BITS - STRIDE_BITS;
  localparam int HALF_W   = 16;
  localparam int WORD_B   = DATA_W / 8;
  localparam int CTRL_REG = NUM_CMD + 1;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic unused_addr;
  assign unused_addr = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[STRIDE_BITS-1:0]};

  // decode
  logic             dec_hit;
  logic [REG_W-1:0] dec_reg;

  mmio_tf_decode #(
    .IDX_W(IDX_W), .REG_W(REG_W), .NUM_CMD(NUM_CMD),
    .CTRL_SLOT0(CTRL_SLOT0), .CTRL_SLOT1(CTRL_SLOT1), .CTRL_REG(CTRL_REG)
  ) u_decode (
    .slot    (bus_addr[WIN_BITS-1:STRIDE_BITS]),
    .size    (bus_size),
    .hit     (dec_hit),
    .reg_sel (dec_reg)
  );

  // lane reversal on both paths
  logic [HALF_W-1:0] wr_half, rd_half;
  logic [DATA_W-1:0] wr_word, rd_word;

  mmio_tf_lane_rev #(.BYTES(2))      u_wr_half (.din(bus_wdata[HALF_W-1:0]), .dout(wr_half));
  mmio_tf_lane_rev #(.BYTES(WORD_B)) u_wr_word (.din(bus_wdata),             .dout(wr_word));
  mmio_tf_lane_rev #(.BYTES(2))      u_rd_half (.din(tf_rdata[HALF_W-1:0]),  .dout(rd_half));
  mmio_tf_lane_rev #(.BYTES(WORD_B)) u_rd_word (.din(tf_rdata),              .dout(rd_word));

  // sequencer state
  seq_state_e       state_q, state_d;
  logic             we_q, hit_q;
  logic [1:0]       size_q;
  logic [REG_W-1:0] reg_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rdata_d, wdata_d;
  logic             rd_q, wr_q, ready_q;
  logic             rd_d, wr_d, ready_d;
  logic             accept, ld_en, cap_en;

  assign accept = bus_req && (state_q == ST_IDLE);
  assign ld_en  = accept;
  assign cap_en = (state_q == ST_XFER) && !we_q;

  always_comb begin
    wdata_d = '0;
    case (acc_size_e'(bus_size))
      SZ_BYTE: wdata_d[7:0]        = bus_wdata[7:0];
      SZ_HALF: wdata_d[HALF_W-1:0] = wr_half;
      default: wdata_d             = wr_word;
    endcase
  end

  always_comb begin
    rdata_d = '0;
    if (hit_q) begin
      case (acc_size_e'(size_q))
        SZ_BYTE: rdata_d[7:0]        = tf_rdata[7:0];
        SZ_HALF: rdata_d[HALF_W-1:0] = rd_half;
        default: rdata_d             = rd_word;
      endcase
    end else begin
      case (acc_size_e'(size_q))
        SZ_BYTE: rdata_d[7:0]        = '1;
        SZ_HALF: rdata_d[HALF_W-1:0] = '1;
        default: rdata_d             = '1;
      endcase
    end
  end

  always_comb begin
    state_d = state_q;
    rd_d    = 1'b0;
    wr_d    = 1'b0;
    ready_d = 1'b0;
    case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_XFER;
        rd_d    = dec_hit && !bus_we;
        wr_d    = dec_hit && bus_we;
      end
      ST_XFER: begin
        state_d = ST_RESP;
        ready_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      size_q  <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (ld_en) begin
      we_q    <= bus_we;
      hit_q   <= dec_hit;
      size_q  <= bus_size;
      reg_q   <= dec_reg;
      wdata_q <= wdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign tf_rd     = rd_q;
  assign tf_wr     = wr_q;
  assign tf_reg    = reg_q;
  assign tf_size   = size_q;
  assign tf_wdata  = wdata_q;
  assign bus_ready = ready_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/mmio_tf_bridge_chk.sv
module mmio_tf_bridge_chk #(
  parameter int REG_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_ready,
  input logic             tf_rd,
  input logic             tf_wr,
  input logic [REG_W-1:0] tf_reg,
  input logic [1:0]       tf_size
);

  // R8: a strobe is a single cycle and is followed by ready
  a_r8_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    tf_rd |=> !tf_rd);
  a_r8_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    tf_wr |=> !tf_wr);
  a_r8_strobe_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |=> bus_ready);
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  // R9: never two strobes at once, never a strobe in the ready cycle
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(tf_rd && tf_wr));
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !(tf_rd || tf_wr));

  // R5: wide accesses only ever reach register 0
  a_r5_wide_data_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((tf_rd || tf_wr) && tf_size != 2'd0) |-> (tf_reg == '0));

  // R3: strobed register numbers stay within 0..8
  a_r3_reg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd || tf_wr) |-> (tf_reg <= REG_W'(8)));

  // R10: reset holds the strobes and ready low
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!tf_rd && !tf_wr && !bus_ready));

endmodule

bind mmio_tf_bridge mmio_tf_bridge_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ready (bus_ready),
  .tf_rd     (tf_rd),
  .tf_wr     (tf_wr),
  .tf_reg    (tf_reg),
  .tf_size   (tf_size)
);

// File: tb/mmio_tf_bridge_tb.sv
module mmio_tf_bridge_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, tf_wdata, tf_rdata;
  logic        bus_ready, tf_rd, tf_wr;
  logic [3:0]  tf_reg;
  logic [1:0]  tf_size;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  mmio_tf_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .tf_reg(tf_reg),
    .tf_size(tf_size), .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural model of one access
  task automatic access(input string tag, input logic [31:0] addr, input int size,
                        input bit we, input logic [31:0] wd, input logic [31:0] dev);
    int slot, exp_reg;
    bit hit;
    logic [31:0] exp_rd, exp_wd;
    slot = int'((addr & 32'hFFF) >> 4);
    hit = 0; exp_reg = 0; exp_rd = 32'hFFFF_FFFF; exp_wd = 32'h0;
    if (size == 0) begin
      hit     = (slot >= 1 && slot <= 7) || slot == 8 || slot == 22;
      exp_reg = (slot == 8 || slot == 22) ? 8 : slot;
      exp_rd  = hit ? {24'h0, dev[7:0]} : 32'h0000_00FF;
      exp_wd  = {24'h0, wd[7:0]};
    end else if (size == 1) begin
      hit    = (slot == 0);
      exp_rd = hit ? {16'h0, dev[7:0], dev[15:8]} : 32'h0000_FFFF;
      exp_wd = {16'h0, wd[7:0], wd[15:8]};
    end else if (size == 2) begin
      hit    = (slot == 0);
      exp_rd = hit ? {dev[7:0], dev[15:8], dev[23:16], dev[31:24]} : 32'hFFFF_FFFF;
      exp_wd = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
    end
    @(negedge clk);
    tf_rdata = dev;
    bus_req = 1; bus_we = we; bus_size = size[1:0]; bus_addr = addr; bus_wdata = wd;
    @(negedge clk);                      // after accepting edge
    bus_req = 0;
    chk(tf_rd == (hit && !we), {tag, " rd strobe"}, {31'h0, tf_rd}, {31'h0, hit && !we});
    chk(tf_wr == (hit && we),  {tag, " wr strobe"}, {31'h0, tf_wr}, {31'h0, hit && we});
    chk(bus_ready == 0, {tag, " R8 ready early"}, {31'h0, bus_ready}, 32'h0);
    if (hit) begin
      chk(tf_reg == 4'(exp_reg), {tag, " reg"}, {28'h0, tf_reg}, 32'(exp_reg));
      if (size != 0) chk(tf_size == size[1:0], {tag, " size"}, {30'h0, tf_size}, 32'(size));
      if (we) chk(tf_wdata == exp_wd, {tag, " wdata"}, tf_wdata, exp_wd);
    end
    @(negedge clk);
    chk(bus_ready == 1, {tag, " R8 ready"}, {31'h0, bus_ready}, 32'h1);
    chk(!tf_rd && !tf_wr, {tag, " R8 strobe width"}, {30'h0, tf_rd, tf_wr}, 32'h0);
    if (!we) chk(bus_rdata == exp_rd, {tag, " rdata"}, bus_rdata, exp_rd);
    @(negedge clk);
    chk(bus_ready == 0, {tag, " R8 ready width"}, {31'h0, bus_ready}, 32'h0);
  endtask

  initial begin
    rst_n = 0; bus_req = 0; bus_we = 0; bus_size = 0; bus_addr = 0; bus_wdata = 0; tf_rdata = 0;
    repeat (3) @(negedge clk);
    chk(!tf_rd && !tf_wr && !bus_ready, "R10 reset state", {29'h0, tf_rd, tf_wr, bus_ready}, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    access("R2 byte rd slot3",   32'h0000_0030, 0, 0, 32'h0,         32'hDEAD_BE5A);
    access("R2 byte wr slot7",   32'h0000_0070, 0, 1, 32'h1234_56C3, 32'h0);
    access("R1 high bits slot5", 32'hABCD_E05C, 0, 0, 32'h0,         32'h0000_0077);
    access("R3 ctrl wr slot8",   32'h0000_0080, 0, 1, 32'h0000_0006, 32'h0);
    access("R3 ctrl wr slot22",  32'h0000_0160, 0, 1, 32'h0000_0002, 32'h0);
    access("R3 altstat rd s22",  32'h0000_0160, 0, 0, 32'h0,         32'h0000_0050);
    access("R4 byte rd slot9",   32'h0000_0090, 0, 0, 32'h0,         32'h1111_1111);
    access("R4 byte wr slot0",   32'h0000_0000, 0, 1, 32'h0000_00AA, 32'h0);
    access("R4 byte rd slot255", 32'h0000_0FF0, 0, 0, 32'h0,         32'h0);
    access("R6 half wr",         32'h0000_0002, 1, 1, 32'h0000_AABB, 32'h0);
    access("R6 half rd",         32'h0000_0000, 1, 0, 32'h0,         32'h5555_CCDD);
    access("R7 word wr",         32'h0000_0000, 2, 1, 32'h1122_3344, 32'h0);
    access("R7 word rd",         32'h0000_1008, 2, 0, 32'h0,         32'h8899_AABB);
    access("R5 half rd slot1",   32'h0000_0010, 1, 0, 32'h0,         32'h1234_5678);
    access("R5 word wr slot2",   32'h0000_0020, 2, 1, 32'hCAFE_F00D, 32'h0);
    access("R5 word rd slot16",  32'h0000_0100, 2, 0, 32'h0,         32'h0);
    access("R5 rsvd size rd",    32'h0000_0000, 3, 0, 32'h0,         32'h1234_5678);

    // R9: request held during the strobe cycle is ignored
    begin
      int extra = 0;
      @(negedge clk);
      tf_rdata = 32'h0000_0011;
      bus_req = 1; bus_we = 0; bus_size = 0; bus_addr = 32'h30;
      @(negedge clk);
      bus_we = 1; bus_addr = 32'h20; bus_wdata = 32'h99;
      @(negedge clk);
      bus_req = 0;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        if (tf_wr || tf_rd) extra++;
      end
      chk(extra == 0, "R9 busy request ignored", 32'(extra), 32'h0);
    end

    // R10: reset in the middle of an access
    begin
      int seen = 0;
      @(negedge clk);
      bus_req = 1; bus_we = 0; bus_size = 0; bus_addr = 32'h40;
      @(negedge clk);
      bus_req = 0;
      rst_n = 0;
      #1;
      chk(!tf_rd, "R10 strobe dropped", {31'h0, tf_rd}, 32'h0);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        if (bus_ready || tf_rd || tf_wr) seen++;
      end
      rst_n = 1;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (bus_ready || tf_rd || tf_wr) seen++;
      end
      chk(seen == 0, "R10 access dropped", 32'(seen), 32'h0);
    end
    access("R10 usable after reset", 32'h0000_0040, 0, 0, 32'h0, 32'h0000_003C);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule